// File: doc/BRIEF.md
# Packet-DMA Channel Register File

This block is the software-visible control store for a two-channel disk packet-DMA controller. A host reaches it over a plain memory-mapped bus with a byte address, a 32-bit write word, four byte strobes and a registered 32-bit read word. For each channel it keeps a control halfword, a status byte, a descriptor count, a next-descriptor pointer and a pair of FIFO thresholds. It drives the packet engine with start, auto-enable, engine reset, drive reset, interrupt mask and PIO mode. It also folds engine events into a status byte that clears when read, and raises one shared interrupt line.

Starting the engine needs a global key. A byte at 0xC7 has to hold the value 7 before any start request is honoured. The engine reset is a level that software raises and then lowers. A start request becomes a single-cycle strobe to the engine and never reads back.

Top module: `pktdma_regfile`

## Requirements
- R1: Channel c occupies byte addresses 0x80+0x20*c to 0x9F+0x20*c. Only word-aligned addresses (address bits 1:0 equal to zero) are decoded. A write to an undefined offset, or to any address outside the channel windows and the key word, changes nothing. A read of such an address returns zero.
- R2: The control halfword at channel offset 0x00 drives the engine outputs until it is rewritten. Bit 8 is the interrupt mask, bit 5 is the engine reset level, bit 3 is auto-enable, bit 2 is the drive hard reset and bits 1:0 are the PIO mode. Byte strobe 0 writes bits 7:0 and strobe 1 writes bit 8. Reads return these bits in the same places, with every other bit reading zero.
- R3: A control write with strobe 0, bit 7 set and bit 5 clear, while the key is armed, produces a go pulse on that channel's output for exactly the one cycle after the write. Bit 7 always reads as zero. A write with bit 5 set produces no pulse.
- R4: The key byte is lane 3 of word 0xC4 (byte 0xC7). It is written only under strobe 3 and reads back in bits 31:24. The key is armed only while it holds 7, and with any other value go requests are ignored.
- R5: The status byte reads back in bits 23:16 of channel offset 0x00. Each event input sets its own bit and the bit stays set: parity error on bit 0, packet done on bit 2, unexpected drive interrupt on bit 4, packet-state error on bit 6.
- R6: A read of channel offset 0x00 with strobe 2 returns the status byte and clears it. An event arriving in the same cycle as that read is kept for the next read.
- R7: The interrupt output is high exactly when some channel has a nonzero status byte and its mask bit is clear.
- R8: Channel offset 0x04 bits 15:0 hold the descriptor count, offset 0x0C holds the 32-bit next-descriptor pointer, and offset 0x14 holds the input threshold in bits 15:0 and the output threshold in bits 31:16. Each byte is written only when its strobe is set.
- R9: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.
- R10: After the synchronous reset, every register, output and the read word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Registered read data |
| ev_parity_i | input | NUM_CH | Parity error event per channel |
| ev_done_i | input | NUM_CH | Packet done event per channel |
| ev_drvirq_i | input | NUM_CH | Unexpected drive interrupt event per channel |
| ev_pktstate_i | input | NUM_CH | Packet-state error event per channel |
| go_o | output | NUM_CH | One-cycle start pulse per channel |
| auto_en_o | output | NUM_CH | Auto-enable per channel |
| eng_rst_o | output | NUM_CH | Engine reset level per channel |
| drv_rst_o | output | NUM_CH | Drive hard reset per channel |
| irq_mask_o | output | NUM_CH | Interrupt mask per channel |
| pio_mode_o | output | 2*NUM_CH | PIO mode, two bits per channel |
| desc_cnt_o | output | 16*NUM_CH | Descriptor count per channel |
| next_desc_o | output | 32*NUM_CH | Next-descriptor pointer per channel |
| fifo_in_thr_o | output | 16*NUM_CH | Input FIFO threshold per channel |
| fifo_out_thr_o | output | 16*NUM_CH | Output FIFO threshold per channel |
| irq_o | output | 1 | Shared interrupt |

## Verification
Two things can happen in the same cycle here: a status read that clears the byte, and a new engine event. The bench drives an event on the same edge where it reads the status word. It then expects the first read to return only the older bits and a second read to return the new one. The same clash is checked when a go request meets the engine reset bit in a single control write. In both cases a behavioural model of the register file is compared against every output on every clock.

// File: rtl/pktdma_pkg.sv
package pktdma_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int SPAN_LG2 = 5;
  localparam int WOFF_W   = SPAN_LG2 - 2;
  localparam int CNT_W    = 16;
  localparam int PTR_W    = 32;
  localparam int THR_W    = 16;
  localparam int LANES    = DATA_W / 8;

  localparam logic [WOFF_W-1:0] W_CTRL = 3'd0;
  localparam logic [WOFF_W-1:0] W_CNT  = 3'd1;
  localparam logic [WOFF_W-1:0] W_PTR  = 3'd3;
  localparam logic [WOFF_W-1:0] W_THR  = 3'd5;

  localparam int C_DRVRST = 2;
  localparam int C_AUTO   = 3;
  localparam int C_ENGRST = 5;
  localparam int C_GO     = 7;
  localparam int C_MASK   = 8;

  localparam int S_PARITY   = 0;
  localparam int S_DONE     = 2;
  localparam int S_DRVIRQ   = 4;
  localparam int S_PKTSTATE = 6;

  typedef struct packed {
    logic       mask;
    logic       eng_rst;
    logic       auto_en;
    logic       drv_rst;
    logic [1:0] pio;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] merge_lanes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [LANES-1:0]  be);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (be[l]) r[8*l +: 8] = new_w[8*l +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pktdma_addr_dec.sv
module pktdma_addr_dec
  import pktdma_pkg::*;
#(
  parameter int              NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] CH_BASE   = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hC7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ch_hit_o,
  output logic [WOFF_W-1:0] woff_o,
  output logic              lock_hit_o
);
  localparam int IDX_W = ADDR_W - SPAN_LG2;
  localparam logic [IDX_W-1:0] BASE_IDX = CH_BASE[ADDR_W-1:SPAN_LG2];

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign woff_o  = addr_i[SPAN_LG2-1:2];
  assign lock_hit_o = aligned && (addr_i[ADDR_W-1:2] == LOCK_ADDR[ADDR_W-1:2]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit_o[c] = aligned &&
      (addr_i[ADDR_W-1:SPAN_LG2] == IDX_W'(int'(BASE_IDX) + c));
  end
endmodule

// File: rtl/pktdma_mode_lock.sv
module pktdma_mode_lock
  import pktdma_pkg::*;
#(
  parameter int         LANE = 3,
  parameter logic [7:0] KEY  = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              hit_i,
  input  logic              be_i,
  input  logic [7:0]        wbyte_i,
  output logic              armed_o,
  output logic [DATA_W-1:0] rword_o
);
  logic [7:0] key_q;

  always_ff @(posedge clk) begin
    if (rst) key_q <= '0;
    else if (wr_i && hit_i && be_i) key_q <= wbyte_i;
  end

  assign armed_o = (key_q == KEY);
  assign rword_o = (rd_i && hit_i) ? (DATA_W'(key_q) << (8*LANE)) : '0;
endmodule

// File: rtl/pktdma_chan.sv
module pktdma_chan
  import pktdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WOFF_W-1:0] woff_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              lock_armed_i,
  input  logic [3:0]        ev_i,
  output logic [DATA_W-1:0] rword_o,
  output logic              go_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [THR_W-1:0]  thr_in_o,
  output logic [THR_W-1:0]  thr_out_o,
  output logic              pend_o
);
  ctrl_t             ctrl_q;
  logic              go_q;
  logic [7:0]        status_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [THR_W-1:0]  thr_in_q, thr_out_q;

  logic              wr_hit, clr;
  logic [7:0]        ev_byte, status_nx;
  logic [DATA_W-1:0] cnt_m, ptr_m, thr_m;
  logic [15:0]       ctrl_rd;
  logic              unused_bits;

  assign wr_hit = wr_i && sel_i;
  assign clr    = rd_i && sel_i && (woff_i == W_CTRL) && be_i[2];

  always_comb begin
    ev_byte             = '0;
    ev_byte[S_PARITY]   = ev_i[0];
    ev_byte[S_DONE]     = ev_i[1];
    ev_byte[S_DRVIRQ]   = ev_i[2];
    ev_byte[S_PKTSTATE] = ev_i[3];
    status_nx = (clr ? 8'h00 : status_q) | ev_byte;
  end

  assign cnt_m = merge_lanes(DATA_W'(cnt_q), wdata_i, be_i);
  assign ptr_m = merge_lanes(DATA_W'(ptr_q), wdata_i, be_i);
  assign thr_m = merge_lanes({thr_out_q, thr_in_q}, wdata_i, be_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      go_q      <= 1'b0;
      status_q  <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      thr_in_q  <= '0;
      thr_out_q <= '0;
    end else begin
      go_q     <= 1'b0;
      status_q <= status_nx;
      if (wr_hit) begin
        case (woff_i)
          W_CTRL: begin
            if (be_i[0]) begin
              ctrl_q.pio     <= wdata_i[1:0];
              ctrl_q.drv_rst <= wdata_i[C_DRVRST];
              ctrl_q.auto_en <= wdata_i[C_AUTO];
              ctrl_q.eng_rst <= wdata_i[C_ENGRST];
              go_q <= wdata_i[C_GO] && !wdata_i[C_ENGRST] && lock_armed_i;
            end
            if (be_i[1]) ctrl_q.mask <= wdata_i[C_MASK];
          end
          W_CNT: cnt_q <= cnt_m[CNT_W-1:0];
          W_PTR: ptr_q <= ptr_m[PTR_W-1:0];
          W_THR: begin
            thr_in_q  <= thr_m[THR_W-1:0];
            thr_out_q <= thr_m[2*THR_W-1:THR_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[1:0]      = ctrl_q.pio;
    ctrl_rd[C_DRVRST] = ctrl_q.drv_rst;
    ctrl_rd[C_AUTO]   = ctrl_q.auto_en;
    ctrl_rd[C_ENGRST] = ctrl_q.eng_rst;
    ctrl_rd[C_MASK]   = ctrl_q.mask;
    rword_o = '0;
    if (rd_i && sel_i) begin
      case (woff_i)
        W_CTRL:  rword_o = {8'h00, status_q, ctrl_rd};
        W_CNT:   rword_o = DATA_W'(cnt_q);
        W_PTR:   rword_o = DATA_W'(ptr_q);
        W_THR:   rword_o = {thr_out_q, thr_in_q};
        default: rword_o = '0;
      endcase
    end
  end

  assign unused_bits = ^{wdata_i[6], wdata_i[4], wdata_i[DATA_W-1:9],
                         cnt_m[DATA_W-1:CNT_W]};

  assign go_o      = go_q;
  assign ctrl_o    = ctrl_q;
  assign cnt_o     = cnt_q;
  assign ptr_o     = ptr_q;
  assign thr_in_o  = thr_in_q;
  assign thr_out_o = thr_out_q;
  assign pend_o    = (status_q != 8'h00);

  // R3: a start pulse never leaves while the engine reset level is held
  assert_go_not_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    go_q |-> !ctrl_q.eng_rst);

  // R5: without a clearing read, no status bit ever drops
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: a clearing read leaves only the events of that same cycle
  assert_clear_keeps_new_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (status_q == $past(ev_byte)));
endmodule

// File: rtl/pktdma_regfile.sv
module pktdma_regfile
  import pktdma_pkg::*;
#(
  parameter int                NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] CH_BASE   = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hC7,
  parameter logic [7:0]        LOCK_KEY  = 8'h07
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [LANES-1:0]        bus_be,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_CH-1:0]       ev_parity_i,
  input  logic [NUM_CH-1:0]       ev_done_i,
  input  logic [NUM_CH-1:0]       ev_drvirq_i,
  input  logic [NUM_CH-1:0]       ev_pktstate_i,
  output logic [NUM_CH-1:0]       go_o,
  output logic [NUM_CH-1:0]       auto_en_o,
  output logic [NUM_CH-1:0]       eng_rst_o,
  output logic [NUM_CH-1:0]       drv_rst_o,
  output logic [NUM_CH-1:0]       irq_mask_o,
  output logic [2*NUM_CH-1:0]     pio_mode_o,
  output logic [CNT_W*NUM_CH-1:0] desc_cnt_o,
  output logic [PTR_W*NUM_CH-1:0] next_desc_o,
  output logic [THR_W*NUM_CH-1:0] fifo_in_thr_o,
  output logic [THR_W*NUM_CH-1:0] fifo_out_thr_o,
  output logic                    irq_o
);
  localparam int LOCK_LANE = int'(LOCK_ADDR[1:0]);

  logic [NUM_CH-1:0] ch_hit, pend;
  logic [WOFF_W-1:0] woff;
  logic              lock_hit, lock_armed;
  logic [DATA_W-1:0] lock_word, rd_word, rdata_q;
  logic [DATA_W-1:0] ch_word [NUM_CH];
  ctrl_t             ctrl   [NUM_CH];

  pktdma_addr_dec #(.NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .LOCK_ADDR(LOCK_ADDR)) u_dec (
    .addr_i(bus_addr), .ch_hit_o(ch_hit), .woff_o(woff), .lock_hit_o(lock_hit));

  pktdma_mode_lock #(.LANE(LOCK_LANE), .KEY(LOCK_KEY)) u_lock (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .hit_i(lock_hit),
    .be_i(bus_be[LOCK_LANE]), .wbyte_i(bus_wdata[8*LOCK_LANE +: 8]),
    .armed_o(lock_armed), .rword_o(lock_word));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pktdma_chan u_chan (
      .clk(clk), .rst(rst), .sel_i(ch_hit[c]), .wr_i(bus_wr), .rd_i(bus_rd),
      .woff_i(woff), .wdata_i(bus_wdata), .be_i(bus_be), .lock_armed_i(lock_armed),
      .ev_i({ev_pktstate_i[c], ev_drvirq_i[c], ev_done_i[c], ev_parity_i[c]}),
      .rword_o(ch_word[c]), .go_o(go_o[c]), .ctrl_o(ctrl[c]),
      .cnt_o(desc_cnt_o[CNT_W*c +: CNT_W]), .ptr_o(next_desc_o[PTR_W*c +: PTR_W]),
      .thr_in_o(fifo_in_thr_o[THR_W*c +: THR_W]),
      .thr_out_o(fifo_out_thr_o[THR_W*c +: THR_W]), .pend_o(pend[c]));

    assign auto_en_o[c]        = ctrl[c].auto_en;
    assign eng_rst_o[c]        = ctrl[c].eng_rst;
    assign drv_rst_o[c]        = ctrl[c].drv_rst;
    assign irq_mask_o[c]       = ctrl[c].mask;
    assign pio_mode_o[2*c +: 2] = ctrl[c].pio;

    // R4: a start pulse only follows a cycle in which the key was armed
    assert_go_needs_key_R4: assert property (@(posedge clk) disable iff (rst)
      go_o[c] |-> $past(lock_armed));
  end

  always_comb begin
    rd_word = lock_word;
    for (int c = 0; c < NUM_CH; c++) rd_word = rd_word | ch_word[c];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = |(pend & ~irq_mask_o);

  // R7: with every channel masked the interrupt line stays low
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask_o) |-> !irq_o);

  // R9: read data only moves after a read strobe
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/pktdma_regfile_test.sv
module pktdma_regfile_test;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] ev_par = '0, ev_done = '0, ev_drv = '0, ev_pks = '0;
  logic [NC-1:0] go_o, auto_en_o, eng_rst_o, drv_rst_o, irq_mask_o;
  logic [2*NC-1:0]  pio_mode_o;
  logic [16*NC-1:0] desc_cnt_o, fin_o, fout_o;
  logic [32*NC-1:0] next_desc_o;
  logic irq_o;

  always #2 clk = ~clk;

  pktdma_regfile uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .ev_parity_i(ev_par), .ev_done_i(ev_done), .ev_drvirq_i(ev_drv),
    .ev_pktstate_i(ev_pks), .go_o(go_o), .auto_en_o(auto_en_o),
    .eng_rst_o(eng_rst_o), .drv_rst_o(drv_rst_o), .irq_mask_o(irq_mask_o),
    .pio_mode_o(pio_mode_o), .desc_cnt_o(desc_cnt_o), .next_desc_o(next_desc_o),
    .fifo_in_thr_o(fin_o), .fifo_out_thr_o(fout_o), .irq_o(irq_o));

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model: byte images of each channel window
  logic [7:0]  mb [NC][32];
  logic [7:0]  st [NC];
  logic [7:0]  key;
  logic [NC-1:0] go_e;
  logic [31:0] rd_e;

  always @(posedge clk) begin
    bit clrf [NC];
    int c, o, b;
    logic [7:0] v;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        for (int j = 0; j < 32; j++) mb[i][j] = 8'h00;
        st[i] = 8'h00;
      end
      key = 8'h00; go_e = '0; rd_e = '0;
    end else begin
      go_e = '0;
      for (int i = 0; i < NC; i++) clrf[i] = 0;
      c = (int'(bus_addr) - 128) / 32;
      o = int'(bus_addr) % 32;
      if (bus_rd) begin
        rd_e = 32'h0;
        if (bus_addr >= 8'h80 && bus_addr < 8'hC0 && bus_addr[1:0] == 2'b00) begin
          for (int l = 0; l < 4; l++) begin
            b = o + l;
            rd_e[8*l +: 8] = (b == 2) ? st[c] : mb[c][b];
          end
          if (o == 0 && bus_be[2]) clrf[c] = 1;
        end else if (bus_addr == 8'hC4) rd_e = {key, 24'h0};
      end
      if (bus_wr) begin
        if (bus_addr >= 8'h80 && bus_addr < 8'hC0 && bus_addr[1:0] == 2'b00) begin
          for (int l = 0; l < 4; l++) if (bus_be[l]) begin
            b = o + l; v = bus_wdata[8*l +: 8];
            if (b == 0) mb[c][0] = v & 8'h2F;
            else if (b == 1) mb[c][1] = v & 8'h01;
            else if (b == 4 || b == 5 || (b >= 12 && b <= 15) || (b >= 20 && b <= 23))
              mb[c][b] = v;
          end
          if (o == 0 && bus_be[0] && bus_wdata[7] && !bus_wdata[5] && key == 8'h07)
            go_e[c] = 1'b1;
        end else if (bus_addr == 8'hC4 && bus_be[3]) key = bus_wdata[31:24];
      end
      for (int i = 0; i < NC; i++)
        st[i] = (clrf[i] ? 8'h00 : st[i]) |
                {1'b0, ev_pks[i], 1'b0, ev_drv[i], 1'b0, ev_done[i], 1'b0, ev_par[i]};
    end
  end

  // compare every output against the model on every cycle
  always @(negedge clk) begin
    logic irq_e;
    irq_e = 1'b0;
    for (int i = 0; i < NC; i++) begin
      logic [7:0] cl;
      cl = mb[i][0];
      if (st[i] != 8'h00 && !mb[i][1][0]) irq_e = 1'b1;
      check(go_o[i] == go_e[i], "R3 go pulse", 64'(go_o[i]), 64'(go_e[i]));
      check({irq_mask_o[i], eng_rst_o[i], auto_en_o[i], drv_rst_o[i], pio_mode_o[2*i +: 2]}
            == {mb[i][1][0], cl[5], cl[3], cl[2], cl[1:0]}, "R2 control outputs",
            64'({irq_mask_o[i], eng_rst_o[i], auto_en_o[i], drv_rst_o[i], pio_mode_o[2*i +: 2]}),
            64'({mb[i][1][0], cl[5], cl[3], cl[2], cl[1:0]}));
      check({desc_cnt_o[16*i +: 16], next_desc_o[32*i +: 32], fout_o[16*i +: 16], fin_o[16*i +: 16]}
            == {mb[i][5], mb[i][4], mb[i][15], mb[i][14], mb[i][13], mb[i][12],
                mb[i][23], mb[i][22], mb[i][21], mb[i][20]}, "R8 count/pointer/thresholds",
            {desc_cnt_o[16*i +: 16], next_desc_o[32*i +: 32], fout_o[16*i +: 16]},
            {mb[i][5], mb[i][4], mb[i][15], mb[i][14], mb[i][13], mb[i][12], mb[i][23], mb[i][22]});
    end
    check(irq_o == irq_e, "R7 interrupt line", 64'(irq_o), 64'(irq_e));
    check(bus_rdata == rd_e, "R9 read data", 64'(bus_rdata), 64'(rd_e));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: everything zero after reset
    check(go_o == 0 && irq_o == 0 && bus_rdata == 0 && desc_cnt_o == 0,
          "R10 reset state", 64'(go_o), 64'h0);

    // R4: go before the key is armed is ignored
    wr(8'h80, 32'h0000_008B, 4'b0011);
    check(go_o[0] == 1'b0, "R4 go without key", 64'(go_o), 64'h0);
    wr(8'hC4, 32'h0700_0000, 4'b1000);
    rd(8'hC4, 4'b1000, v);
    check(v == 32'h0700_0000, "R4 key readback", 64'(v), 64'h0700_0000);

    // R2: engine reset sequence, reset level then PIO only
    wr(8'h80, 32'h0000_0123, 4'b0011);
    check(eng_rst_o[0] && irq_mask_o[0] && pio_mode_o[1:0] == 2'd3,
          "R2 reset level held", 64'({eng_rst_o[0], irq_mask_o[0]}), 64'h3);
    wr(8'h80, 32'h0000_0003, 4'b0011);
    check(!eng_rst_o[0] && !irq_mask_o[0], "R2 reset released",
          64'(eng_rst_o[0]), 64'h0);

    // R3: armed go gives a single pulse, and reads back as zero
    wr(8'h80, 32'h0000_008B, 4'b0011);
    check(go_o == 2'b01, "R3 go pulse after write", 64'(go_o), 64'h1);
    @(negedge clk);
    check(go_o == 2'b00, "R3 go lasts one cycle", 64'(go_o), 64'h0);
    rd(8'h80, 4'b0011, v);
    check(v == 32'h0000_000B, "R3 go reads zero", 64'(v), 64'h0B);
    wr(8'h80, 32'h0000_00A3, 4'b0001);
    check(go_o == 2'b00 && eng_rst_o[0], "R3 go blocked by engine reset", 64'(go_o), 64'h0);
    wr(8'h80, 32'h0000_0003, 4'b0001);

    // R8: channel 1 count, pointer, thresholds with byte strobes
    wr(8'hA4, 32'hFFFF_1234, 4'b0011);
    rd(8'hA4, 4'b1111, v);
    check(v == 32'h0000_1234, "R8 count upper lanes ignored", 64'(v), 64'h1234);
    wr(8'hAC, 32'hDEAD_BEEF, 4'b1111);
    wr(8'hAC, 32'h0055_0000, 4'b0100);
    check(next_desc_o[63:32] == 32'hDE55_BEEF, "R8 pointer byte write",
          64'(next_desc_o[63:32]), 64'hDE55BEEF);
    wr(8'hB4, 32'h0100_0100, 4'b1111);
    check(fin_o[31:16] == 16'h0100 && fout_o[31:16] == 16'h0100, "R8 thresholds",
          64'({fout_o[31:16], fin_o[31:16]}), 64'h01000100);

    // R1: undefined offset, unaligned and outside addresses
    wr(8'h9C, 32'hFFFF_FFFF, 4'b1111);
    wr(8'h60, 32'hFFFF_FFFF, 4'b1111);
    wr(8'h85, 32'hFFFF_FFFF, 4'b1111);
    rd(8'h9C, 4'b1111, v);
    check(v == 32'h0, "R1 undefined offset reads zero", 64'(v), 64'h0);
    rd(8'h60, 4'b1111, v);
    check(v == 32'h0, "R1 outside address reads zero", 64'(v), 64'h0);
    rd(8'h80, 4'b0011, v);
    check(v == 32'h0000_0003, "R1 stray writes left control alone", 64'(v), 64'h3);

    // R5/R7: events on channel 1
    @(negedge clk); ev_par[1] = 1'b1; ev_drv[1] = 1'b1;
    @(negedge clk); ev_par = '0; ev_drv = '0;
    check(irq_o == 1'b1, "R7 interrupt on pending status", 64'(irq_o), 64'h1);
    // R6: read clears, same-cycle event survives
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'hA0; bus_be = 4'b0100; ev_pks[1] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; ev_pks = '0;
    check(bus_rdata[23:16] == 8'h11, "R5 status bits latched", 64'(bus_rdata[23:16]), 64'h11);
    rd(8'hA0, 4'b0100, v);
    check(v[23:16] == 8'h40, "R6 event during clear kept", 64'(v[23:16]), 64'h40);
    rd(8'hA0, 4'b0100, v);
    check(v[23:16] == 8'h00 && irq_o == 1'b0, "R6 status cleared",
          64'(v[23:16]), 64'h0);

    // R7: masked channel does not interrupt
    wr(8'h80, 32'h0000_0100, 4'b0010);
    @(negedge clk); ev_done[0] = 1'b1;
    @(negedge clk); ev_done = '0;
    check(irq_o == 1'b0, "R7 masked event", 64'(irq_o), 64'h0);
    wr(8'h80, 32'h0000_0000, 4'b0010);
    check(irq_o == 1'b1, "R7 unmask exposes pending", 64'(irq_o), 64'h1);
    rd(8'h80, 4'b0100, v);
    check(v[23:16] == 8'h04, "R5 done bit", 64'(v[23:16]), 64'h04);

    // R4: key changed away from 7 disarms go
    wr(8'hC4, 32'h0500_0000, 4'b1000);
    wr(8'hA0, 32'h0000_0088, 4'b0001);
    check(go_o == 2'b00, "R4 disarmed key blocks go", 64'(go_o), 64'h0);
    wr(8'hC4, 32'h0700_0000, 4'b0111);
    wr(8'hA0, 32'h0000_0088, 4'b0001);
    check(go_o == 2'b00, "R4 key needs lane 3 strobe", 64'(go_o), 64'h0);
    wr(8'hC4, 32'h0700_0000, 4'b1000);
    wr(8'hA0, 32'h0000_0088, 4'b0001);
    check(go_o == 2'b10, "R3 go on channel 1", 64'(go_o), 64'h2);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule